// File: doc/BRIEF.md
# Table-Driven Setpoint Edge Generator

This block produces the power setpoint for a sampled control loop. It holds two shape tables, one for rising edges and one for falling edges. A host fills both tables once through a simple write port. A single trigger, qualified by a rise/fall select, then plays the chosen table. The block moves one entry forward on every control-loop sample tick. Each table value is a normalized scale from 0 % (0x0000) to 100 % (0xFFFF). It is multiplied by a 16-bit amplitude input to give a 32-bit unsigned setpoint.

When the sequencer reaches the final table entry, it stops advancing. That entry then acts as the steady-state scale until the next trigger. A new trigger always restarts from entry 0 of the table it selects, even in the middle of an edge. Host writes and sequencer reads can hit the same table in the same clock cycle. They are ordered by a fixed rule: a table that is not being stepped gives the host write priority, and a table that is being stepped delays the host write by one cycle.

Top module: `setpoint_edge_gen`

## Requirements
- R1: After reset the setpoint is 0. It stays 0 until the first trigger, whatever table writes or sample ticks arrive before then.
- R2: A trigger (`edge_trig`=1) starts an edge at entry 0 of the table chosen by `edge_fall` (0 = rising table, 1 = falling table). The product for entry 0 appears on the second rising clock edge after the trigger is sampled.
- R3: While an edge is being stepped, each sampled `sample_tick` advances the entry index by exactly one. The product for the new entry appears on the second rising clock edge after the tick is sampled.
- R4: Once the last entry (DEPTH-1) is reached, stepping stops and that entry is held. Further ticks leave the setpoint unchanged.
- R5: The setpoint equals the current table value times `amp`, as a full 32-bit unsigned product. A change of `amp` reaches the setpoint one clock edge later, during stepping and during hold.
- R6: A trigger that arrives during an edge restarts from entry 0 of the newly selected table. A trigger and a tick sampled in the same cycle act as a trigger alone.
- R7: A host write stores `host_wr_data` at `host_wr_addr` of the table chosen by `host_wr_fall` (0 = rising, 1 = falling). The other table is left unchanged.
- R8: A host write to a table that is not being stepped takes effect at once. A sequencer read of the same entry in the same cycle returns the newly written value.
- R9: A host write to the table that is being stepped is applied one cycle late. A sequencer read of that entry in the write cycle returns the old value, and later reads return the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr_en | input | 1 | Host table write strobe |
| host_wr_fall | input | 1 | Host write target: 0 rising table, 1 falling table |
| host_wr_addr | input | 8 | Host write entry index |
| host_wr_data | input | 16 | Host write normalized scale value |
| edge_trig | input | 1 | Start an edge |
| edge_fall | input | 1 | Edge select at trigger: 0 rising, 1 falling |
| sample_tick | input | 1 | Control-loop sample strobe, one entry per pulse |
| amp | input | 16 | Amplitude multiplier |
| setpoint | output | 32 | Scaled setpoint, table value times amplitude |

## Verification
A host write and a sequencer read can hit the same entry of the same table in one cycle. This happens through a trigger or through a tick during stepping. The bench provokes this collision in both ownership states. It pairs a trigger with a write to entry 0 of a table that is not being stepped; the setpoint must then show the new value. It pairs a tick with a write to the next entry of the table that is being stepped; the setpoint must show the old value, and a retriggered playback must later show the new one.

// File: rtl/setpoint_edge_pkg.sv
package setpoint_edge_pkg;

    // Which of the two shape tables an edge or a write addresses
    typedef enum logic {
        SHAPE_RISE = 1'b0,
        SHAPE_FALL = 1'b1
    } shape_sel_e;

    localparam int unsigned NUM_SHAPES = 2;

endpackage

// File: rtl/setpoint_shape_table.sv
// One shape memory with a write port, a registered read port and a
// one-entry queue that defers host writes while the table is being stepped.
module setpoint_shape_table #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 256,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    typedef struct packed {
        logic              pend_v;
        logic [ADDR_W-1:0] pend_addr;
        logic [DATA_W-1:0] pend_data;
        logic [DATA_W-1:0] rdata;
    } tbl_state_t;

    tbl_state_t st_d, st_q;

    logic [DATA_W-1:0] mem [DEPTH];

    logic              port_we;
    logic [ADDR_W-1:0] port_addr;
    logic [DATA_W-1:0] port_data;

    always_comb begin
        st_d      = st_q;
        port_we   = 1'b0;
        port_addr = wr_addr;
        port_data = wr_data;

        // A deferred write always owns the port in the cycle after it was queued
        if (st_q.pend_v) begin
            port_we   = 1'b1;
            port_addr = st_q.pend_addr;
            port_data = st_q.pend_data;
        end else if (wr_en && !busy) begin
            port_we   = 1'b1;
        end

        // Defer while stepping, or while the queue slot is still draining
        st_d.pend_v    = wr_en && (busy || st_q.pend_v);
        st_d.pend_addr = wr_addr;
        st_d.pend_data = wr_data;

        // Write-first forwarding on a same-entry collision
        if (rd_en) begin
            if (port_we && (port_addr == rd_addr)) begin
                st_d.rdata = port_data;
            end else begin
                st_d.rdata = mem[rd_addr];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (port_we) begin
            mem[port_addr] <= port_data;
        end
    end

    assign rd_data = st_q.rdata;

endmodule

// File: rtl/setpoint_edge_seq.sv
// Read sequencer: trigger restarts at entry 0, ticks advance, last entry holds.
module setpoint_edge_seq
    import setpoint_edge_pkg::*;
#(
    parameter int unsigned DEPTH  = 256,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic              trig_fall,
    input  logic              tick,
    output logic              rd_en,
    output logic              rd_fall,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              run,
    output logic              sel_fall,
    output logic [ADDR_W-1:0] idx
);

    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(DEPTH - 1);

    typedef struct packed {
        logic              run;
        shape_sel_e        sel;
        logic [ADDR_W-1:0] idx;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        rd_en   = 1'b0;
        rd_fall = (st_q.sel == SHAPE_FALL);
        rd_addr = st_q.idx + 1'b1;

        if (trig) begin
            // Trigger outranks a coincident tick
            st_d.run  = 1'b1;
            st_d.sel  = shape_sel_e'(trig_fall);
            st_d.idx  = '0;
            rd_en     = 1'b1;
            rd_fall   = trig_fall;
            rd_addr   = '0;
        end else if (st_q.run && tick) begin
            st_d.idx  = st_q.idx + 1'b1;
            rd_en     = 1'b1;
            if (st_d.idx == LAST_IDX) begin
                st_d.run = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{run: 1'b0, sel: SHAPE_RISE, idx: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign run      = st_q.run;
    assign sel_fall = (st_q.sel == SHAPE_FALL);
    assign idx      = st_q.idx;

endmodule

// File: rtl/setpoint_scaler.sv
// Registered full-width unsigned product of scale and amplitude.
module setpoint_scaler #(
    parameter int unsigned SCALE_W = 16,
    parameter int unsigned AMP_W   = 16,
    localparam int unsigned PROD_W = SCALE_W + AMP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SCALE_W-1:0] scale,
    input  logic [AMP_W-1:0]   amp,
    output logic [PROD_W-1:0]  prod
);

    typedef struct packed {
        logic [PROD_W-1:0] prod;
    } scl_state_t;

    scl_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prod = PROD_W'(scale) * PROD_W'(amp);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign prod = st_q.prod;

endmodule

// File: rtl/setpoint_edge_gen.sv
module setpoint_edge_gen
    import setpoint_edge_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 256,
    parameter int unsigned AMP_W  = 16,
    localparam int unsigned ADDR_W = $clog2(DEPTH),
    localparam int unsigned OUT_W  = DATA_W + AMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_en,
    input  logic              host_wr_fall,
    input  logic [ADDR_W-1:0] host_wr_addr,
    input  logic [DATA_W-1:0] host_wr_data,
    input  logic              edge_trig,
    input  logic              edge_fall,
    input  logic              sample_tick,
    input  logic [AMP_W-1:0]  amp,
    output logic [OUT_W-1:0]  setpoint
);

    logic              seq_rd_en;
    logic              seq_rd_fall;
    logic [ADDR_W-1:0] seq_rd_addr;
    logic              seq_run;
    logic              seq_sel;
    logic [ADDR_W-1:0] seq_idx;

    logic [NUM_SHAPES-1:0] tbl_wr_en;
    logic [NUM_SHAPES-1:0] tbl_rd_en;
    logic [NUM_SHAPES-1:0] tbl_busy;
    logic [DATA_W-1:0]     tbl_rd_data [NUM_SHAPES];
    logic [DATA_W-1:0]     cur_scale;

    setpoint_edge_seq #(
        .DEPTH (DEPTH)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (edge_trig),
        .trig_fall(edge_fall),
        .tick     (sample_tick),
        .rd_en    (seq_rd_en),
        .rd_fall  (seq_rd_fall),
        .rd_addr  (seq_rd_addr),
        .run      (seq_run),
        .sel_fall (seq_sel),
        .idx      (seq_idx)
    );

    for (genvar g = 0; g < NUM_SHAPES; g++) begin : g_shape
        assign tbl_wr_en[g] = host_wr_en && (host_wr_fall == 1'(g));
        assign tbl_rd_en[g] = seq_rd_en  && (seq_rd_fall  == 1'(g));
        assign tbl_busy[g]  = seq_run    && (seq_sel      == 1'(g));

        setpoint_shape_table #(
            .DATA_W (DATA_W),
            .DEPTH  (DEPTH)
        ) u_table (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (tbl_wr_en[g]),
            .wr_addr(host_wr_addr),
            .wr_data(host_wr_data),
            .busy   (tbl_busy[g]),
            .rd_en  (tbl_rd_en[g]),
            .rd_addr(seq_rd_addr),
            .rd_data(tbl_rd_data[g])
        );
    end

    // The selected table's read register doubles as the held scale
    assign cur_scale = tbl_rd_data[seq_sel];

    setpoint_scaler #(
        .SCALE_W(DATA_W),
        .AMP_W  (AMP_W)
    ) u_scaler (
        .clk  (clk),
        .rst_n(rst_n),
        .scale(cur_scale),
        .amp  (amp),
        .prod (setpoint)
    );

endmodule

// File: rtl/setpoint_edge_gen_chk.sv
module setpoint_edge_gen_chk #(
    parameter int unsigned IDX_W = 8,
    parameter int unsigned AMP_W = 16,
    parameter int unsigned OUT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             edge_trig,
    input logic             sample_tick,
    input logic [AMP_W-1:0] amp,
    input logic [OUT_W-1:0] setpoint,
    input logic             seq_run,
    input logic             seq_sel,
    input logic [IDX_W-1:0] seq_idx
);

    logic warm_q;
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm_q <= 1'b0;
            seen_q <= 1'b0;
        end else begin
            warm_q <= 1'b1;
            seen_q <= seen_q | edge_trig;
        end
    end

    p_zero_before_trigger_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> (setpoint == '0));

    p_run_started_by_trigger_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q && $rose(seq_run)) |-> $past(edge_trig));

    p_tick_advances_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_run && sample_tick && !edge_trig) |=> (seq_idx == IDX_W'($past(seq_idx) + 1'b1)));

    p_hold_index_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_run && !edge_trig) |=> ($stable(seq_idx) && !seq_run));

    p_hold_output_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q && !$past(edge_trig) && !$past(seq_run) && (amp == $past(amp))) |=> $stable(setpoint));

    p_trigger_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        edge_trig |=> (seq_run && (seq_idx == '0)));

    p_select_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_trig |=> $stable(seq_sel));

endmodule

bind setpoint_edge_gen setpoint_edge_gen_chk #(
    .IDX_W(ADDR_W),
    .AMP_W(AMP_W),
    .OUT_W(OUT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .edge_trig  (edge_trig),
    .sample_tick(sample_tick),
    .amp        (amp),
    .setpoint   (setpoint),
    .seq_run    (seq_run),
    .seq_sel    (seq_sel),
    .seq_idx    (seq_idx)
);

// File: tb/setpoint_edge_gen_bench.sv
module setpoint_edge_gen_bench;

    localparam int DEPTH = 256;
    localparam int LAST  = DEPTH - 1;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_wr_en;
    logic        host_wr_fall;
    logic [7:0]  host_wr_addr;
    logic [15:0] host_wr_data;
    logic        edge_trig;
    logic        edge_fall;
    logic        sample_tick;
    logic [15:0] amp;
    logic [31:0] setpoint;

    always #2 clk = ~clk;

    setpoint_edge_gen u_setpoint_edge_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_wr_en  (host_wr_en),
        .host_wr_fall(host_wr_fall),
        .host_wr_addr(host_wr_addr),
        .host_wr_data(host_wr_data),
        .edge_trig   (edge_trig),
        .edge_fall   (edge_fall),
        .sample_tick (sample_tick),
        .amp         (amp),
        .setpoint    (setpoint)
    );

    // Vector: {select, amplitude, tick count}
    localparam logic [32:0] VECS [6] = '{
        {1'b0, 16'h0001, 16'd5},
        {1'b1, 16'hFFFF, 16'd3},
        {1'b0, 16'hFFFF, 16'd260},
        {1'b1, 16'h1234, 16'd256},
        {1'b0, 16'h0000, 16'd4},
        {1'b1, 16'h8000, 16'd10}
    };

    logic [15:0] rise_m [DEPTH];
    logic [15:0] fall_m [DEPTH];
    logic        cur_fall;
    int          cur_idx;
    logic [15:0] cur_amp;
    int          n_checks = 0;
    int          n_fails  = 0;
    bit          done     = 1'b0;

    function automatic logic [31:0] expect_sp();
        logic [15:0] s;
        s = cur_fall ? fall_m[cur_idx] : rise_m[cur_idx];
        return 32'(s) * 32'(cur_amp);
    endfunction

    task automatic check(input string req, input logic [31:0] exp);
        n_checks++;
        if (setpoint !== exp) begin
            n_fails++;
            $display("FAIL %s: setpoint actual=%h expected=%h", req, setpoint, exp);
        end
    endtask

    task automatic host_write(input logic f, input int a, input logic [15:0] d);
        host_wr_en   = 1'b1;
        host_wr_fall = f;
        host_wr_addr = 8'(a);
        host_wr_data = d;
        @(negedge clk);
        host_wr_en   = 1'b0;
        if (f) fall_m[a] = d; else rise_m[a] = d;
    endtask

    task automatic trigger(input logic f, input logic [15:0] a);
        edge_trig = 1'b1;
        edge_fall = f;
        amp       = a;
        @(negedge clk);
        edge_trig = 1'b0;
        @(negedge clk);
        cur_fall = f;
        cur_idx  = 0;
        cur_amp  = a;
    endtask

    task automatic tick_once();
        sample_tick = 1'b1;
        @(negedge clk);
        sample_tick = 1'b0;
        @(negedge clk);
        if (cur_idx < LAST) cur_idx++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; host_wr_en = 1'b0; host_wr_fall = 1'b0; host_wr_addr = '0;
        host_wr_data = '0; edge_trig = 1'b0; edge_fall = 1'b0; sample_tick = 1'b0;
        amp = 16'h4321; cur_fall = 1'b0; cur_idx = 0; cur_amp = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 32'h0);  // reset state

        // R7: load both tables through the host port
        for (int i = 0; i < DEPTH; i++) host_write(1'b0, i, 16'(i * 257));
        for (int i = 0; i < DEPTH; i++) host_write(1'b1, i, 16'(16'hFFFF - i * 251));
        check("R1", 32'h0);  // loaded tables alone do not move the output
        tick_once();
        check("R1", 32'h0);  // idle ticks ignored

        // Vector walk: R2 start, R3 stepping, R4 hold, R5 scaling
        for (int v = 0; v < 6; v++) begin
            trigger(VECS[v][32], VECS[v][31:16]);
            check("R2", expect_sp());
            for (int t = 0; t < int'(VECS[v][15:0]); t++) begin
                tick_once();
                if (cur_idx == LAST) check("R4", expect_sp());
                else                 check("R3", expect_sp());
            end
        end

        // R5: amplitude change during hold, one edge later
        trigger(1'b0, 16'h00FF);
        for (int t = 0; t < DEPTH; t++) tick_once();
        check("R4", expect_sp());
        amp = 16'hABCD;
        cur_amp = 16'hABCD;
        @(negedge clk);
        check("R5", expect_sp());
        tick_once();
        check("R4", expect_sp());

        // R6: retrigger mid-edge into the other table
        trigger(1'b0, 16'h0777);
        for (int t = 0; t < 3; t++) tick_once();
        check("R3", expect_sp());
        trigger(1'b1, 16'h0777);
        check("R6", expect_sp());
        tick_once();
        check("R6", expect_sp());

        // R6: trigger and tick in one cycle act as trigger alone
        edge_trig = 1'b1; edge_fall = 1'b0; sample_tick = 1'b1;
        @(negedge clk);
        edge_trig = 1'b0; sample_tick = 1'b0;
        @(negedge clk);
        cur_fall = 1'b0; cur_idx = 0;
        check("R6", expect_sp());

        // R8: write to a table not being stepped, same cycle as its start read
        trigger(1'b1, 16'h3000);
        edge_trig = 1'b1; edge_fall = 1'b0;
        host_wr_en = 1'b1; host_wr_fall = 1'b0; host_wr_addr = 8'd0; host_wr_data = 16'h5A5A;
        @(negedge clk);
        edge_trig = 1'b0; host_wr_en = 1'b0;
        rise_m[0] = 16'h5A5A;
        @(negedge clk);
        cur_fall = 1'b0; cur_idx = 0;
        check("R8", expect_sp());

        // R9: write to the stepped table, same cycle as the tick reading that entry
        sample_tick = 1'b1;
        host_wr_en = 1'b1; host_wr_fall = 1'b0; host_wr_addr = 8'd1; host_wr_data = 16'hC3C3;
        @(negedge clk);
        sample_tick = 1'b0; host_wr_en = 1'b0;
        @(negedge clk);
        cur_idx = 1;
        check("R9", expect_sp());  // old entry value still read
        rise_m[1] = 16'hC3C3;
        trigger(1'b0, 16'h3000);
        tick_once();
        check("R9", expect_sp());  // deferred write landed

        // R7: write to the idle table while the other one steps
        host_write(1'b1, 1, 16'h1111);
        trigger(1'b1, 16'h0002);
        tick_once();
        check("R7", expect_sp());
        trigger(1'b0, 16'h0002);
        tick_once();
        check("R7", expect_sp());  // rising table untouched

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule